// File: doc/BRIEF.md
# Hall-Sensor Bridge Commutator with Over-Current Kill

This block turns the three Hall sensor lines of a brushless motor into the six gate drives of a three-phase bridge. The Hall lines are first brought into the clock domain and filtered. The filtered code then selects one of six commutation steps. Each step names a source phase, a sink phase and one idle phase. The source phase switches with the PWM carrier: its high-side gate follows the carrier and its low-side gate follows the inverse. The sink phase holds its low-side gate on. The idle phase keeps both gates off. A programmable dead time keeps the two gates of a phase from overlapping.

An over-current flag comes from an external shunt comparator. It is registered and then latched. While it is latched, all six gates stay off until the run enable is dropped. A direction input reverses the rotation. Codes that cannot occur on a healthy sensor set turn the bridge off and raise a fault flag.

Top module: `bldc_commutator`

## Requirements
- R1: After reset, all six gate outputs are low, `hallFault` is 1 (the filtered code resets to 000) and `ocFault` is 0.
- R2: Each Hall line passes a two-flop synchroniser. A new code is accepted only after three consecutive equal synchronised samples, so a change that lasts two clocks or less leaves the gate outputs unchanged.
- R3: With `dirRev`=0 the code `hallIn`={H1,H2,H3} (H1 is bit 2) selects a source and a sink phase as follows: 101 gives A and B, 100 gives A and C, 110 gives B and C, 010 gives B and A, 011 gives C and A, 001 gives C and B. In the gate vectors phase A is bit 0, B is bit 1 and C is bit 2.
- R4: Once settled, the source phase has its high gate equal to `pwmIn` and its low gate equal to the inverse of `pwmIn`. The sink phase has its low gate at 1 and its high gate at 0. The idle phase has both gates at 0.
- R5: With `dirRev`=1 the roles of source and sink for every code are exchanged.
- R6: The codes 000 and 111 drive all six gates low and hold `hallFault` at 1. A valid code clears `hallFault` and restores the drive.
- R7: The two gates of one phase are never high together. Between one gate of a phase turning off and the other turning on, both stay low for exactly max(`deadCfg`,1) clocks.
- R8: `ocIn` is registered. Once it is high, all gates are low from the second rising clock edge onward, and `ocFault` is 1 from that same edge.
- R9: `ocFault` and the gate cutoff persist after `ocIn` returns low, for as long as `runEn` stays high. They clear while `runEn` is low and `ocIn` is low. Drive resumes when `runEn` rises again.
- R10: While `runEn` is low, all six gates are low.
- R11: At most one high-side gate is on in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hallIn | input | 3 | Raw Hall lines {H1,H2,H3} |
| pwmIn | input | 1 | PWM carrier, synchronous to clk |
| runEn | input | 1 | Run enable; low forces the bridge off and clears the kill latch |
| dirRev | input | 1 | 1 selects reverse rotation |
| ocIn | input | 1 | Over-current flag from the shunt comparator |
| deadCfg | input | DEAD_W (6) | Dead time in clocks, 0 to 63 |
| gateHi | output | 3 | High-side gates, bit 0 = phase A |
| gateLo | output | 3 | Low-side gates, bit 0 = phase A |
| hallFault | output | 1 | Filtered Hall code is 000 or 111 |
| ocFault | output | 1 | Over-current kill latched |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, a three-sample filter and a six-bit dead-time field. With these values both ends of the dead-time range can be measured: the setting 0, which still gives a one-clock gap, and the full setting of 63. The filter boundary is also in reach, because a two-clock Hall glitch must be rejected. Both rotation directions are walked through all six codes, and the carrier is checked at each level.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

  // Strobes from the control side to the gate datapath (one-hot phases, bit 0 = A)
  typedef struct packed {
    logic       kill;
    logic [2:0] src;
    logic [2:0] snk;
  } drive_t;

  // Filtered Hall code -> {source, sink}; invalid codes give no phases
  function automatic logic [5:0] pairOf(input logic [2:0] code);
    case (code)
      3'b101:  pairOf = {3'b001, 3'b010};
      3'b100:  pairOf = {3'b001, 3'b100};
      3'b110:  pairOf = {3'b010, 3'b100};
      3'b010:  pairOf = {3'b010, 3'b001};
      3'b011:  pairOf = {3'b100, 3'b001};
      3'b001:  pairOf = {3'b100, 3'b010};
      default: pairOf = 6'b000000;
    endcase
  endfunction

endpackage

// File: rtl/hall_ctrl.sv
module hall_ctrl
  import bldc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hallIn,
  input  logic       runEn,
  input  logic       dirRev,
  input  logic       ocIn,
  output drive_t     drv,
  output logic       hallFault,
  output logic       ocFault
);

  localparam int HIST = FILT_LEN - 1;

  logic [2:0] syncQ [SYNC_STAGES];
  logic [2:0] hist  [HIST];
  logic [2:0] syncOut;
  logic [2:0] stableCode;
  logic       agree;
  logic       ocReg;
  logic       ocLatch;
  logic [5:0] pair;
  logic       hallBad;

  assign syncOut = syncQ[SYNC_STAGES-1];

  // Synchroniser chain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncQ[k] <= 3'b000;
    end else begin
      syncQ[0] <= hallIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
    end
  end

  // Sample history for the glitch filter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < HIST; k++) hist[k] <= 3'b000;
    end else begin
      hist[0] <= syncOut;
      for (int k = 1; k < HIST; k++) hist[k] <= hist[k-1];
    end
  end

  always_comb begin
    agree = 1'b1;
    for (int k = 0; k < HIST; k++) begin
      if (hist[k] != syncOut) agree = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      stableCode <= 3'b000;
    else if (agree) stableCode <= syncOut;
  end

  // Over-current register and kill latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ocReg   <= 1'b0;
      ocLatch <= 1'b0;
    end else begin
      ocReg <= ocIn;
      if (ocReg)       ocLatch <= 1'b1;
      else if (!runEn) ocLatch <= 1'b0;
    end
  end

  assign hallBad   = (stableCode == 3'b000) || (stableCode == 3'b111);
  assign pair      = pairOf(stableCode);
  assign drv.src   = dirRev ? pair[2:0] : pair[5:3];
  assign drv.snk   = dirRev ? pair[5:3] : pair[2:0];
  assign drv.kill  = !runEn || ocReg || ocLatch || hallBad;
  assign hallFault = hallBad;
  assign ocFault   = ocLatch;

  AST_OC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ocFault && runEn) |=> ocFault); // R9
  AST_PHASE_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    (drv.src & drv.snk) == 3'b000); // R3
  AST_BAD_CODE_KILL: assert property (@(posedge clk) disable iff (!rstN)
    hallFault |-> drv.kill); // R6

endmodule

// File: rtl/gate_dp.sv
module gate_dp
  import bldc_pkg::*;
#(
  parameter int DEAD_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwmIn,
  input  logic [DEAD_W-1:0] deadCfg,
  input  drive_t            drv,
  output logic [2:0]        gateHi,
  output logic [2:0]        gateLo
);

  localparam logic [DEAD_W-1:0] IDLE_MAX = {DEAD_W{1'b1}};

  for (genvar ph = 0; ph < 3; ph++) begin : g_phase
    logic              hiReq;
    logic              loReq;
    logic              hiQ;
    logic              loQ;
    logic              gapDone;
    logic [DEAD_W-1:0] idleCnt;

    assign hiReq   = drv.src[ph] & pwmIn & ~drv.kill;
    assign loReq   = ((drv.src[ph] & ~pwmIn) | drv.snk[ph]) & ~drv.kill;
    assign gapDone = ({1'b0, idleCnt} + 1'b1) >= {1'b0, deadCfg};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hiQ     <= 1'b0;
        loQ     <= 1'b0;
        idleCnt <= IDLE_MAX;
      end else begin
        hiQ <= hiReq & (hiQ | (~loQ & gapDone));
        loQ <= loReq & (loQ | (~hiQ & gapDone));
        if (hiQ || loQ)            idleCnt <= '0;
        else if (idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
      end
    end

    assign gateHi[ph] = hiQ;
    assign gateLo[ph] = loQ;

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rstN)
      !(gateHi[ph] && gateLo[ph])); // R7
    AST_HI_AFTER_LO_OFF: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateHi[ph]) |-> !$past(gateLo[ph])); // R7
  end

  AST_KILL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    drv.kill |=> (gateHi == 3'b000 && gateLo == 3'b000)); // R8
  AST_HI_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gateHi)); // R11

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int DEAD_W      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        hallIn,
  input  logic              pwmIn,
  input  logic              runEn,
  input  logic              dirRev,
  input  logic              ocIn,
  input  logic [DEAD_W-1:0] deadCfg,
  output logic [2:0]        gateHi,
  output logic [2:0]        gateLo,
  output logic              hallFault,
  output logic              ocFault
);

  drive_t drv;

  hall_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hallIn   (hallIn),
    .runEn    (runEn),
    .dirRev   (dirRev),
    .ocIn     (ocIn),
    .drv      (drv),
    .hallFault(hallFault),
    .ocFault  (ocFault)
  );

  gate_dp #(
    .DEAD_W(DEAD_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .pwmIn  (pwmIn),
    .deadCfg(deadCfg),
    .drv    (drv),
    .gateHi (gateHi),
    .gateLo (gateLo)
  );

endmodule

// File: tb/bldc_commutator_bench.sv
`timescale 1ns/1ps
module bldc_commutator_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hallIn = 3'b000;
  logic       pwmIn = 1'b0;
  logic       runEn = 1'b0;
  logic       dirRev = 1'b0;
  logic       ocIn = 1'b0;
  logic [5:0] deadCfg = 6'd0;
  logic [2:0] gateHi;
  logic [2:0] gateLo;
  logic       hallFault;
  logic       ocFault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bldc_commutator u_bldc_commutator (
    .clk(clk), .rstN(rstN), .hallIn(hallIn), .pwmIn(pwmIn), .runEn(runEn),
    .dirRev(dirRev), .ocIn(ocIn), .deadCfg(deadCfg), .gateHi(gateHi),
    .gateLo(gateLo), .hallFault(hallFault), .ocFault(ocFault)
  );

  // {hall code, source one-hot, sink one-hot}, forward direction (R3)
  localparam logic [8:0] VEC [6] = '{
    9'b101_001_010, 9'b100_001_100, 9'b110_010_100,
    9'b010_010_001, 9'b011_100_001, 9'b001_100_010
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // pwm rising: count cycles phase A has both gates low until high gate turns on
  task automatic gapLoToHi(output int gap);
    pwmIn = 1'b1;
    gap = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (gateHi[0]) break;
      if (!gateLo[0]) gap++;
    end
  endtask

  task automatic gapHiToLo(output int gap);
    pwmIn = 1'b0;
    gap = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (gateLo[0]) break;
      if (!gateHi[0]) gap++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int gap;
    bit glitchOk;
    logic [2:0] src, snk;

    tick(4);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 gates", {2'b00, gateHi, gateLo}, 8'h00);
    chk("R1 flags", {6'b0, hallFault, ocFault}, 8'b10);

    runEn = 1'b1;
    deadCfg = 6'd3;

    // R3 R4 R5: table walk in both directions, both carrier levels
    for (int d = 0; d < 2; d++) begin
      for (int v = 0; v < 6; v++) begin
        dirRev = d[0];
        hallIn = VEC[v][8:6];
        src = d[0] ? VEC[v][2:0] : VEC[v][5:3];
        snk = d[0] ? VEC[v][5:3] : VEC[v][2:0];
        pwmIn = 1'b1;
        tick(20);
        chk(d[0] ? "R5 pwm high" : "R3 pwm high", {2'b00, gateHi, gateLo}, {2'b00, src, snk});
        chk("R11 single high side", {7'b0, $onehot0(gateHi)}, 8'd1);
        pwmIn = 1'b0;
        tick(10);
        chk(d[0] ? "R5 pwm low" : "R4 pwm low", {2'b00, gateHi, gateLo}, {2'b00, 3'b000, src | snk});
        chk("R6 valid code", {7'b0, hallFault}, 8'd0);
      end
    end

    // R2 glitch of two clocks is ignored
    dirRev = 1'b0;
    hallIn = 3'b101;
    pwmIn = 1'b1;
    tick(20);
    hallIn = 3'b100;
    tick(2);
    hallIn = 3'b101;
    glitchOk = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (gateHi !== 3'b001 || gateLo !== 3'b010) glitchOk = 1'b0;
    end
    chk("R2 glitch rejected", {7'b0, glitchOk}, 8'd1);

    // R7 dead time at 5, 0 and 63
    deadCfg = 6'd5;
    tick(80);
    gapHiToLo(gap);
    chk("R7 gap hi->lo dead5", gap[7:0], 8'd5);
    tick(80);
    gapLoToHi(gap);
    chk("R7 gap lo->hi dead5", gap[7:0], 8'd5);
    deadCfg = 6'd0;
    tick(10);
    gapHiToLo(gap);
    chk("R7 gap dead0", gap[7:0], 8'd1);
    deadCfg = 6'd63;
    tick(80);
    gapLoToHi(gap);
    chk("R7 gap dead63", gap[7:0], 8'd63);
    deadCfg = 6'd2;
    pwmIn = 1'b1;
    tick(20);

    // R6 invalid codes
    hallIn = 3'b000;
    tick(20);
    chk("R6 code 000", {1'b0, hallFault, gateHi, gateLo}, 8'b0100_0000);
    hallIn = 3'b111;
    tick(20);
    chk("R6 code 111", {1'b0, hallFault, gateHi, gateLo}, 8'b0100_0000);
    hallIn = 3'b101;
    tick(20);
    chk("R6 recovery", {1'b0, hallFault, gateHi, gateLo}, 8'b0000_1010);

    // R8 over-current timing
    ocIn = 1'b1;
    @(negedge clk);
    chk("R8 one edge later still on", {2'b00, gateHi, gateLo}, 8'b00_001_010);
    @(negedge clk);
    chk("R8 two edges later off", {1'b0, ocFault, gateHi, gateLo}, 8'b0100_0000);

    // R9 latch holds after flag drops
    ocIn = 1'b0;
    tick(20);
    chk("R9 latch holds", {1'b0, ocFault, gateHi, gateLo}, 8'b0100_0000);

    // R10 run low clears latch, gates stay off
    runEn = 1'b0;
    tick(5);
    chk("R10 run low", {1'b0, ocFault, gateHi, gateLo}, 8'b0000_0000);
    runEn = 1'b1;
    tick(20);
    chk("R9 drive resumes", {1'b0, ocFault, gateHi, gateLo}, 8'b0000_1010);

    // R10 run low without a fault
    runEn = 1'b0;
    tick(10);
    chk("R10 run low no fault", {2'b00, gateHi, gateLo}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule